// File: doc/BRIEF.md
# Fault Flag and Error Pin Controller

This block gathers fault conditions from a motor bridge driver's analog monitors and keeps each one as a sticky status flag that the host reads over its serial link. It drives an active-low error line to the host and asserts a bridge-disable signal that turns all gate drivers off. The safety-mode pin chooses between full protection, where every fault reports and every protective fault disables the bridge, and configurable protection, where per-fault enables decide both.

A flag clears on a read of its status register only once the fault condition has gone. A read while the condition is still present leaves the flag set and sends a short high pulse on the error line. This lets the host tell a condition that persists from one that has already cleared. A self-test bit forces the supply undervoltage and overvoltage conditions together, so the comparator path and the error line can be exercised in place. Supply undervoltage and boost undervoltage pass a persistence filter before they set their flags.

Top module: `fault_err_ctrl`

## Requirements
- R1: After reset, stat_flags is 5'b10000 (bit0 supply undervoltage, bit1 supply overvoltage, bit2 boost undervoltage, bit3 overtemperature warning, bit4 serial-access OK, which is active high). err_n is 1 and bridge_off is 0.
- R2: stat_flags[0] (from vs_uv_raw) and stat_flags[2] (from bst_uv_raw) set only after the raw input has been sampled high on FILT_CYC consecutive clock edges. The flag shows the cycle after that. A shorter high run sets nothing.
- R3: stat_flags[1] (vs_ov_raw) and stat_flags[3] (ot_warn_raw) are set in the cycle after the raw input is sampled high.
- R4: A flag clears in the cycle after a read of its register only if its condition is absent at that read. rd_stat0 serves bit3. rd_stat1 serves bits 0, 1, 2 and 4. A read of the other register leaves the flag unchanged.
- R5: A read that finds a reportable flag set and its condition still present keeps the flag set. err_n is then 1 for PULSE_CYC cycles starting the cycle after the read, and returns to 0 afterwards.
- R6: While cfg_selftest is 1, the flags in bits 0 and 1 are set. They clear only after cfg_selftest returns to 0 and a later rd_stat1 is issued.
- R7: A spi_bad strobe drives stat_flags[4] to 0 in the next cycle. A following rd_stat1 with no new strobe returns it to 1.
- R8: With csm=0 (full safety), any set flag (bits 0 to 3 at 1, or bit4 at 0) drives err_n to 0. The overvoltage and boost flags drive bridge_off to 1.
- R9: With csm=1 (configurable), cfg_err_en[i] gates whether flag i (bit4 meaning the access-error state) can pull err_n low. cfg_prot_en[0] gates overvoltage and cfg_prot_en[1] gates boost on bridge_off. Flags set in every mode.
- R10: The undervoltage, overtemperature and serial-access flags never assert bridge_off.
- R11: When the last reportable flag clears on a read, err_n is 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vs_uv_raw | input | 1 | Supply undervoltage comparator |
| vs_ov_raw | input | 1 | Supply overvoltage comparator |
| bst_uv_raw | input | 1 | Boost output undervoltage comparator |
| ot_warn_raw | input | 1 | Overtemperature warning comparator |
| spi_bad | input | 1 | One-cycle strobe for an invalid serial access |
| rd_stat0 | input | 1 | Read strobe of status register 0 (bit3) |
| rd_stat1 | input | 1 | Read strobe of status register 1 (bits 0, 1, 2, 4) |
| csm | input | 1 | Safety-mode pin: 0 full, 1 configurable |
| cfg_selftest | input | 1 | Comparator and clock self-test bit |
| cfg_prot_en | input | 2 | Configurable mode protection enables: bit0 OV, bit1 boost |
| cfg_err_en | input | 5 | Configurable mode error-line enables, per flag bit |
| stat_flags | output | 5 | Latched status flags |
| bridge_off | output | 1 | Turn all gate drivers off |
| err_n | output | 1 | Active-low error line to the host |

## Verification
The bench builds the block with FILT_CYC=6 and PULSE_CYC=2. The short filter brings the exact persistence boundary within a few cycles: one edge short and exactly enough. The two-cycle pulse shows both the pulse start and its end before err_n drops again. A long random run switches the safety mode and the enable masks while faults overlap with reads. It reaches reads in the same cycle as a new fault, and self-test overlapping real faults.

// File: rtl/fec_pkg.sv
package fec_pkg;
  localparam int NF      = 5;
  localparam int FI_UV   = 0;
  localparam int FI_OV   = 1;
  localparam int FI_BST  = 2;
  localparam int FI_OT   = 3;
  localparam int FI_SPI  = 4;
  localparam int NFILT   = 2;
  localparam int NPROT   = 2;
endpackage

// File: rtl/fec_filter.sv
module fec_filter #(
  parameter int FILT_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = raw || (cnt_q != '0);
    if (!raw)             cnt_d = '0;
    else if (cnt_q == LIM) cnt_d = cnt_q;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign filt = (cnt_q == LIM);
endmodule

// File: rtl/fec_flag.sv
module fec_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic rd,
  output logic flag
);
  logic flag_d, flag_en;

  always_comb begin
    flag_en = cond || rd;
    flag_d  = cond || (flag && !rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_d;
  end
endmodule

// File: rtl/fec_pulse.sv
module fec_pulse #(
  parameter int PULSE_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int PCW = $clog2(PULSE_CYC + 1);
  localparam logic [PCW-1:0] PLEN = PCW'(PULSE_CYC);

  logic [PCW-1:0] pc_q, pc_d;
  logic           pc_en;

  always_comb begin
    pc_en = trig || (pc_q != '0);
    if (trig) pc_d = PLEN;
    else      pc_d = pc_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign active = (pc_q != '0);
endmodule

// File: rtl/fault_err_ctrl.sv
module fault_err_ctrl
  import fec_pkg::*;
#(
  parameter int FILT_CYC  = 50,
  parameter int PULSE_CYC = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vs_uv_raw,
  input  logic            vs_ov_raw,
  input  logic            bst_uv_raw,
  input  logic            ot_warn_raw,
  input  logic            spi_bad,
  input  logic            rd_stat0,
  input  logic            rd_stat1,
  input  logic            csm,
  input  logic            cfg_selftest,
  input  logic [NPROT-1:0] cfg_prot_en,
  input  logic [NF-1:0]   cfg_err_en,
  output logic [NF-1:0]   stat_flags,
  output logic            bridge_off,
  output logic            err_n
);
  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // persistence filters for the two slow undervoltage monitors
  logic [NFILT-1:0] filt_raw, filt_out;
  assign filt_raw = {bst_uv_raw, vs_uv_raw};

  for (genvar g = 0; g < NFILT; g++) begin : g_filt
    fec_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .raw  (filt_raw[g]),
      .filt (filt_out[g])
    );
  end

  // effective conditions, self-test forcing both supply comparators
  logic [NF-1:0] cond, rd_sel, flag_q;
  always_comb begin
    cond         = '0;
    cond[FI_UV]  = filt_out[0] || cfg_selftest;
    cond[FI_OV]  = vs_ov_raw  || cfg_selftest;
    cond[FI_BST] = filt_out[1];
    cond[FI_OT]  = ot_warn_raw;
    cond[FI_SPI] = spi_bad;
    rd_sel         = {NF{rd_stat1}};
    rd_sel[FI_OT]  = rd_stat0;
  end

  for (genvar f = 0; f < NF; f++) begin : g_flag
    fec_flag u_flag (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .cond (cond[f]),
      .rd   (rd_sel[f]),
      .flag (flag_q[f])
    );
  end

  // safety-mode masks
  logic [NF-1:0]    rep_en;
  logic [NPROT-1:0] prot_en;
  always_comb begin
    rep_en  = csm ? cfg_err_en  : '1;
    prot_en = csm ? cfg_prot_en : '1;
  end

  // read-while-present pulse on the error line
  logic pulse_trig, pulse_on;
  assign pulse_trig = |(rd_sel & flag_q & cond & rep_en);

  fec_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .trig  (pulse_trig),
    .active(pulse_on)
  );

  always_comb begin
    stat_flags         = flag_q;
    stat_flags[FI_SPI] = !flag_q[FI_SPI];
    bridge_off = (flag_q[FI_OV] && prot_en[0]) || (flag_q[FI_BST] && prot_en[1]);
    err_n      = !(|(flag_q & rep_en)) || pulse_on;
  end
endmodule

// File: rtl/fec_chk.sv
module fec_chk (
  input logic       clk,
  input logic       rst_i,
  input logic       vs_uv_raw,
  input logic       vs_ov_raw,
  input logic       rd_stat1,
  input logic       csm,
  input logic       cfg_selftest,
  input logic [4:0] stat_flags,
  input logic       bridge_off,
  input logic       err_n
);
  assert_uv_filtered_R2: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(stat_flags[0]) |-> ($past(cfg_selftest) || $past(vs_uv_raw, 2)));

  assert_ov_sets_R3: assert property (@(posedge clk) disable iff (!rst_i)
    vs_ov_raw |=> stat_flags[1]);

  assert_clear_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(stat_flags[1]) |-> $past(rd_stat1));

  assert_pulse_on_read_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_stat1 && vs_ov_raw && stat_flags[1] && !csm) |=> err_n);

  assert_selftest_forces_R6: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_selftest |=> (stat_flags[0] && stat_flags[1]));

  assert_spi_ok_read_R7: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(stat_flags[4]) |-> $past(rd_stat1));

  assert_err_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_i)
    !err_n |-> ((stat_flags[3:0] != 4'd0) || !stat_flags[4]));

  assert_full_mode_off_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (!csm && (stat_flags[1] || stat_flags[2])) |-> bridge_off);

  assert_off_cause_R10: assert property (@(posedge clk) disable iff (!rst_i)
    bridge_off |-> (stat_flags[1] || stat_flags[2]));
endmodule

bind fault_err_ctrl fec_chk u_chk (
  .clk         (clk),
  .rst_i       (rst_sync_n),
  .vs_uv_raw   (vs_uv_raw),
  .vs_ov_raw   (vs_ov_raw),
  .rd_stat1    (rd_stat1),
  .csm         (csm),
  .cfg_selftest(cfg_selftest),
  .stat_flags  (stat_flags),
  .bridge_off  (bridge_off),
  .err_n       (err_n)
);

// File: tb/fault_err_ctrl_tb.sv
module fault_err_ctrl_tb;
  localparam int F  = 6;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic vs_uv_raw, vs_ov_raw, bst_uv_raw, ot_warn_raw, spi_bad;
  logic rd_stat0, rd_stat1, csm, cfg_selftest;
  logic [1:0] cfg_prot_en;
  logic [4:0] cfg_err_en;
  logic [4:0] stat_flags;
  logic bridge_off, err_n;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  fault_err_ctrl #(.FILT_CYC(F), .PULSE_CYC(PW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .vs_uv_raw(vs_uv_raw), .vs_ov_raw(vs_ov_raw), .bst_uv_raw(bst_uv_raw),
    .ot_warn_raw(ot_warn_raw), .spi_bad(spi_bad),
    .rd_stat0(rd_stat0), .rd_stat1(rd_stat1), .csm(csm),
    .cfg_selftest(cfg_selftest), .cfg_prot_en(cfg_prot_en), .cfg_err_en(cfg_err_en),
    .stat_flags(stat_flags), .bridge_off(bridge_off), .err_n(err_n)
  );

  // reference state, from the requirements
  int       m_uvc, m_bc, m_pc;
  bit [4:0] m_f;   // bit4 = access error (active high)

  function automatic bit [4:0] rep_mask();
    return csm ? cfg_err_en : 5'h1f;
  endfunction

  function automatic bit [4:0] exp_stat();
    return {~m_f[4], m_f[3:0]};
  endfunction

  function automatic bit exp_bridge();
    bit [1:0] pe = csm ? cfg_prot_en : 2'b11;
    return (m_f[1] && pe[0]) || (m_f[2] && pe[1]);
  endfunction

  function automatic bit exp_err_n();
    return !(|(m_f & rep_mask())) || (m_pc != 0);
  endfunction

  task automatic model_update();
    bit [4:0] c, r;
    c[0] = (m_uvc == F) || cfg_selftest;
    c[1] = vs_ov_raw || cfg_selftest;
    c[2] = (m_bc == F);
    c[3] = ot_warn_raw;
    c[4] = spi_bad;
    r = {rd_stat1, rd_stat0, rd_stat1, rd_stat1, rd_stat1};
    if (|(r & m_f & c & rep_mask())) m_pc = PW;
    else if (m_pc != 0)              m_pc = m_pc - 1;
    m_f   = c | (m_f & ~r);
    m_uvc = vs_uv_raw  ? ((m_uvc == F) ? F : m_uvc + 1) : 0;
    m_bc  = bst_uv_raw ? ((m_bc  == F) ? F : m_bc  + 1) : 0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    chk("R4 flags vs model", 32'(stat_flags), 32'(exp_stat()));
    chk("R8 bridge_off vs model", 32'(bridge_off), 32'(exp_bridge()));
    chk("R5 err_n vs model", 32'(err_n), 32'(exp_err_n()));
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_model();
  endtask

  task automatic idle_inputs();
    vs_uv_raw = 0; vs_ov_raw = 0; bst_uv_raw = 0; ot_warn_raw = 0;
    spi_bad = 0; rd_stat0 = 0; rd_stat1 = 0; cfg_selftest = 0;
  endtask

  task automatic rd1_once();
    rd_stat1 = 1; step(); rd_stat1 = 0;
  endtask

  initial begin
    void'($urandom(32'd20240917));
    idle_inputs();
    csm = 0; cfg_prot_en = 2'b00; cfg_err_en = 5'h00;
    m_uvc = 0; m_bc = 0; m_pc = 0; m_f = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) step();
    chk("R1 reset flags", 32'(stat_flags), 32'h10);
    chk("R1 reset err_n", 32'(err_n), 32'h1);
    chk("R1 reset bridge_off", 32'(bridge_off), 32'h0);

    // R2: one edge short of the filter, then exactly enough
    vs_uv_raw = 1; repeat (F - 1) step(); vs_uv_raw = 0; repeat (3) step();
    chk("R2 short undervoltage run", 32'(stat_flags[0]), 32'h0);
    vs_uv_raw = 1; repeat (F) step(); vs_uv_raw = 0; step();
    chk("R2 full undervoltage run", 32'(stat_flags[0]), 32'h1);
    chk("R8 full mode err_n low", 32'(err_n), 32'h0);
    chk("R10 undervoltage no bridge_off", 32'(bridge_off), 32'h0);
    rd1_once();
    chk("R4 cleared after read", 32'(stat_flags[0]), 32'h0);
    chk("R11 err_n high after clearing read", 32'(err_n), 32'h1);

    // R3/R5: overvoltage, read while present, then clear
    vs_ov_raw = 1; step();
    chk("R3 overvoltage next cycle", 32'(stat_flags[1]), 32'h1);
    chk("R8 overvoltage bridge_off", 32'(bridge_off), 32'h1);
    rd1_once();
    chk("R5 flag kept on read", 32'(stat_flags[1]), 32'h1);
    chk("R5 pulse first cycle", 32'(err_n), 32'h1);
    step();
    chk("R5 pulse second cycle", 32'(err_n), 32'h1);
    step();
    chk("R5 err_n low after pulse", 32'(err_n), 32'h0);
    vs_ov_raw = 0; step(); rd1_once();
    chk("R4 overvoltage cleared", 32'(stat_flags[1]), 32'h0);

    // R4 mapping: overtemperature only clears on its own register
    ot_warn_raw = 1; step(); ot_warn_raw = 0; step();
    rd1_once();
    chk("R4 wrong register keeps OT", 32'(stat_flags[3]), 32'h1);
    rd_stat0 = 1; step(); rd_stat0 = 0;
    chk("R4 OT cleared by its read", 32'(stat_flags[3]), 32'h0);

    // R6 self-test
    cfg_selftest = 1; step();
    chk("R6 self-test forces flags", 32'(stat_flags[1:0]), 32'h3);
    rd1_once();
    chk("R6 read during self-test keeps", 32'(stat_flags[1:0]), 32'h3);
    step(); step();
    cfg_selftest = 0; step(); rd1_once();
    chk("R6 cleared after bit off and read", 32'(stat_flags[1:0]), 32'h0);

    // R7 serial access status
    spi_bad = 1; step(); spi_bad = 0;
    chk("R7 access OK drops", 32'(stat_flags[4]), 32'h0);
    rd1_once();
    chk("R7 access OK restored", 32'(stat_flags[4]), 32'h1);

    // R9 configurable mode masks
    csm = 1; cfg_err_en = 5'h00; cfg_prot_en = 2'b00;
    vs_ov_raw = 1; step(); vs_ov_raw = 0; step();
    chk("R9 flag still set", 32'(stat_flags[1]), 32'h1);
    chk("R9 masked err_n stays high", 32'(err_n), 32'h1);
    chk("R9 masked bridge_off", 32'(bridge_off), 32'h0);
    cfg_prot_en = 2'b01; cfg_err_en = 5'h02; step();
    chk("R9 enabled bridge_off", 32'(bridge_off), 32'h1);
    chk("R9 enabled err_n low", 32'(err_n), 32'h0);
    rd1_once();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 10 == 0) vs_uv_raw   = ~vs_uv_raw;
      if ($urandom % 9  == 0) bst_uv_raw  = ~bst_uv_raw;
      if ($urandom % 20 == 0) vs_ov_raw   = ~vs_ov_raw;
      if ($urandom % 25 == 0) ot_warn_raw = ~ot_warn_raw;
      if ($urandom % 70 == 0) cfg_selftest = ~cfg_selftest;
      spi_bad  = ($urandom % 30 == 0);
      rd_stat0 = ($urandom % 4 == 0);
      rd_stat1 = ($urandom % 4 == 0);
      if (i % 256 == 0) begin
        csm         = 1'($urandom);
        cfg_prot_en = 2'($urandom);
        cfg_err_en  = 5'($urandom);
      end
      step();
    end
    idle_inputs();
    repeat (F + 2) step();
    rd_stat0 = 1; rd_stat1 = 1; step(); idle_inputs(); step();
    chk("R4 all clear after final reads", 32'(stat_flags), 32'h10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule